// File: doc/BRIEF.md
# Serial Flash Clock and Chip-Select Timing Generator

This block produces the serial clock and the chip-select waveforms for a four-lane serial flash controller running at single data rate. The serial clock is derived from the kernel clock through a programmable divider. A phase sequencer asks for a transfer with a one-cycle start pulse and ends it with a one-cycle stop pulse. In return the block tells the sequencer, one kernel clock at a time, when to launch the next bit and when to capture incoming data.

Between two transfers the chip select is held high for a programmable minimum number of serial clock periods. The clock rests either low or high between transfers (SPI mode 0 or mode 3). A select bit steers the transfer to one of two active-low chip-select lines. A shift option moves the capture strobe half a serial clock later, to tolerate slow flash output paths. The divider, gap length, rest level, line select and shift option are held in a configuration set that is only written while the block is idle.

Top module: `sfc_clk_cs_timing`

## Requirements
- R1: After reset both chip-select lines are high, SCLK is low, busy is low and neither strobe is asserted.
- R2: With a prescaler value p of 1 or more, one SCLK period lasts D = p + 1 kernel clocks. SCLK is low for ceil(D/2) of them and high for floor(D/2), so odd ratios give a high phase one kernel clock shorter than the low phase.
- R3: With prescaler 0, SCLK toggles on every kernel clock during a transfer, so D is 2.
- R4: When no transfer is running, SCLK rests at the level of the rest-level bit: 0 rests low (mode 0) and 1 rests high (mode 3). A new setting shows on SCLK two cycles after the write cycle. Each transfer opens with SCLK at its rest level for the length of that level's phase.
- R5: Chip select is active low. Select value 0 drives line 0 low and select value 1 drives line 1 low, and at most one line is low at any time.
- R6: A start pulse sampled while busy is low pulls the selected line low and raises busy in the next cycle. A start pulse sampled while busy is high is ignored.
- R7: A stop pulse ends the transfer at the close of the current SCLK period. Chip select rises in the same cycle in which SCLK returns to its rest level.
- R8: After chip select rises, busy stays high for exactly (c + 1) * D kernel clocks, where c is the 3-bit gap setting. Chip select therefore stays high for at least c + 1 SCLK periods.
- R9: Every strobe is one kernel clock wide. The drive strobe coincides with every falling SCLK edge. With shift off, the sample strobe coincides with every rising SCLK edge.
- R10: With shift on, the sample strobe fires floor(D/2) kernel clocks after each rising SCLK edge. This includes the last rising edge when it falls on the chip-select rise.
- R11: A configuration write is taken only in a cycle where busy is low and no start is sampled. Otherwise it is ignored, and the rest level, timing and line select stay as before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_presc_i | input | 8 | Clock divider setting p |
| cfg_csht_i | input | 3 | Chip-select gap setting c |
| cfg_idle_high_i | input | 1 | SCLK rest level (0 low / mode 0, 1 high / mode 3) |
| cfg_sel_i | input | 1 | Chip-select line select |
| cfg_sshift_i | input | 1 | Delay capture strobe by half a serial clock |
| xfer_start_i | input | 1 | Transfer start pulse from the sequencer |
| xfer_stop_i | input | 1 | Transfer stop pulse from the sequencer |
| sclk_o | output | 1 | Serial flash clock |
| cs_n_o | output | 2 | Active-low chip-select lines |
| drive_stb_o | output | 1 | Launch strobe, one kernel clock wide |
| sample_stb_o | output | 1 | Capture strobe, one kernel clock wide |
| busy_o | output | 1 | Transfer or chip-select gap in progress |

## Verification
The assertions assume that the sequencer raises start only while busy is low. They also assume that stop arrives only during a transfer, and that a configuration write never shares a cycle with a start. They rely on the frozen configuration to keep the phase lengths constant inside a transfer and its gap. The stimulus honours all of this: every transfer waits for busy to fall, and the stop pulse is placed in the first cycle of the final period. The only deliberate breaches are a start pulse and an inverted configuration write injected inside the gap, where the block has to discard them.

// File: rtl/sfc_timing_pkg.sv
package sfc_timing_pkg;

  typedef enum logic [1:0] {
    XS_IDLE   = 2'd0,
    XS_ACTIVE = 2'd1,
    XS_GAP    = 2'd2
  } xfer_state_e;

endpackage

// File: rtl/sfc_cfg_regs.sv
module sfc_cfg_regs #(
  parameter int PRESC_W = 8,
  parameter int CSHT_W  = 3,
  parameter int SEL_W   = 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_i,
  input  logic               busy_i,
  input  logic               start_i,
  input  logic [PRESC_W-1:0] presc_i,
  input  logic [CSHT_W-1:0]  csht_i,
  input  logic               idle_high_i,
  input  logic [SEL_W-1:0]   sel_i,
  input  logic               sshift_i,
  output logic [PRESC_W-1:0] presc_o,
  output logic [CSHT_W-1:0]  csht_o,
  output logic               idle_high_o,
  output logic [SEL_W-1:0]   sel_o,
  output logic               sshift_o
);

  logic accept;
  assign accept = wr_i && !busy_i && !start_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      presc_o     <= '0;
      csht_o      <= '0;
      idle_high_o <= 1'b0;
      sel_o       <= '0;
      sshift_o    <= 1'b0;
    end else if (accept) begin
      presc_o     <= presc_i;
      csht_o      <= csht_i;
      idle_high_o <= idle_high_i;
      sel_o       <= sel_i;
      sshift_o    <= sshift_i;
    end
  end

  // R11: settings are frozen while a transfer or gap is in progress
  a_r11_frozen_when_busy: assert property (@(posedge clk) disable iff (rst)
    busy_i |=> $stable({presc_o, csht_o, idle_high_o, sel_o, sshift_o}));

endmodule

// File: rtl/sfc_sclk_gen.sv
module sfc_sclk_gen #(
  parameter int PRESC_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               run_i,
  input  logic [PRESC_W-1:0] presc_i,
  input  logic               idle_high_i,
  output logic               sclk_o,
  output logic               rise_o,
  output logic               fall_o,
  output logic               period_last_o,
  output logic [PRESC_W:0]   ratio_o,
  output logic [PRESC_W:0]   half_o
);

  localparam int RW = PRESC_W + 1;

  logic [RW-1:0] ratio, half, rest, len_a, len_b, cur_len, cnt_q;
  logic          ph_q, sclk_q, rise_q, fall_q, phase_end;

  // prescaler 0 cannot be met with registered edges: run at two kernel clocks
  assign ratio   = (presc_i == '0) ? RW'(2) : ({1'b0, presc_i} + RW'(1));
  assign half    = ratio >> 1;
  assign rest    = ratio - half;
  // phase A sits at the rest level, phase B at the opposite level
  assign len_a   = idle_high_i ? half : rest;
  assign len_b   = idle_high_i ? rest : half;
  assign cur_len = ph_q ? len_b : len_a;

  assign phase_end     = run_i && (cnt_q == (cur_len - RW'(1)));
  assign period_last_o = phase_end && ph_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      ph_q   <= 1'b0;
      sclk_q <= 1'b0;
      rise_q <= 1'b0;
      fall_q <= 1'b0;
    end else begin
      rise_q <= 1'b0;
      fall_q <= 1'b0;
      if (!run_i) begin
        cnt_q  <= '0;
        ph_q   <= 1'b0;
        sclk_q <= idle_high_i;
      end else if (phase_end) begin
        cnt_q  <= '0;
        ph_q   <= ~ph_q;
        sclk_q <= ~sclk_q;
        rise_q <= ~sclk_q;
        fall_q <= sclk_q;
      end else begin
        cnt_q <= cnt_q + RW'(1);
      end
    end
  end

  assign sclk_o  = sclk_q;
  assign rise_o  = rise_q;
  assign fall_o  = fall_q;
  assign ratio_o = ratio;
  assign half_o  = half;

  // R4: outside a transfer the clock settles at the configured rest level
  a_r4_rest_level: assert property (@(posedge clk) disable iff (rst)
    !run_i |=> (sclk_q == $past(idle_high_i)));

  // R9: edge strobes line up with the actual SCLK transitions
  a_r9_rise_on_edge: assert property (@(posedge clk) disable iff (rst)
    rise_q |-> (sclk_q && !$past(sclk_q)));
  a_r9_fall_on_edge: assert property (@(posedge clk) disable iff (rst)
    fall_q |-> (!sclk_q && $past(sclk_q)));
  a_r9_rise_one_wide: assert property (@(posedge clk) disable iff (rst)
    rise_q |=> !rise_q);
  a_r9_fall_one_wide: assert property (@(posedge clk) disable iff (rst)
    fall_q |=> !fall_q);

endmodule

// File: rtl/sfc_xfer_fsm.sv
module sfc_xfer_fsm
  import sfc_timing_pkg::*;
#(
  parameter int CSHT_W   = 3,
  parameter int RW       = 9,
  parameter int CS_COUNT = 2,
  parameter int SEL_W    = 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start_i,
  input  logic                stop_i,
  input  logic                period_last_i,
  input  logic [CSHT_W-1:0]   csht_i,
  input  logic [RW-1:0]       ratio_i,
  input  logic [SEL_W-1:0]    sel_i,
  output xfer_state_e         state_o,
  output logic [CS_COUNT-1:0] cs_n_o,
  output logic                busy_o
);

  localparam int GW = RW + CSHT_W;

  xfer_state_e         state_q;
  logic                stop_pend_q;
  logic [GW-1:0]       gap_cnt_q, gap_len;
  logic [CS_COUNT-1:0] cs_n_q, sel_mask;

  assign gap_len = (GW'(csht_i) + GW'(1)) * GW'(ratio_i);

  for (genvar gi = 0; gi < CS_COUNT; gi++) begin : g_sel
    assign sel_mask[gi] = (sel_i == SEL_W'(gi));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= XS_IDLE;
      stop_pend_q <= 1'b0;
      gap_cnt_q   <= '0;
      cs_n_q      <= '1;
    end else begin
      unique case (state_q)
        XS_IDLE: begin
          if (start_i) begin
            state_q     <= XS_ACTIVE;
            stop_pend_q <= 1'b0;
            cs_n_q      <= ~sel_mask;
          end
        end
        XS_ACTIVE: begin
          if (stop_i) stop_pend_q <= 1'b1;
          if (period_last_i && (stop_pend_q || stop_i)) begin
            state_q     <= XS_GAP;
            stop_pend_q <= 1'b0;
            gap_cnt_q   <= '0;
            cs_n_q      <= '1;
          end
        end
        XS_GAP: begin
          if (gap_cnt_q == (gap_len - GW'(1))) state_q <= XS_IDLE;
          else gap_cnt_q <= gap_cnt_q + GW'(1);
        end
        default: state_q <= XS_IDLE;
      endcase
    end
  end

  assign state_o = state_q;
  assign cs_n_o  = cs_n_q;
  assign busy_o  = (state_q != XS_IDLE);

  // checker state for the minimum chip-select high time
  logic [GW:0]   hi_cnt_q;
  logic [GW-1:0] need_q;
  logic          seen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_cnt_q <= '0;
      need_q   <= '0;
      seen_q   <= 1'b0;
    end else begin
      if (!(&cs_n_q)) hi_cnt_q <= '0;
      else if (hi_cnt_q != '1) hi_cnt_q <= hi_cnt_q + (GW+1)'(1);
      if (busy_o && !(&cs_n_q)) need_q <= gap_len;
      seen_q <= seen_q || !(&cs_n_q);
    end
  end

  // R5: never more than one chip select active
  a_r5_single_select: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~cs_n_q));

  // R6: an active chip select always comes with busy
  a_r6_select_implies_busy: assert property (@(posedge clk) disable iff (rst)
    !(&cs_n_q) |-> busy_o);

  // R8: chip select was high for at least the programmed gap before reselecting
  a_r8_min_high_time: assert property (@(posedge clk) disable iff (rst)
    (seen_q && $fell(&cs_n_q)) |-> (hi_cnt_q >= {1'b0, need_q}));

endmodule

// File: rtl/sfc_sample_align.sv
module sfc_sample_align #(
  parameter int RW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rise_i,
  input  logic          fall_i,
  input  logic [RW-1:0] half_i,
  input  logic          shift_i,
  output logic          drive_o,
  output logic          sample_o
);

  logic [RW-1:0] dly_q;
  logic          smp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      dly_q <= '0;
      smp_q <= 1'b0;
    end else begin
      smp_q <= (rise_i && (half_i == RW'(1))) || (dly_q == RW'(1));
      if (rise_i && (half_i > RW'(1))) dly_q <= half_i - RW'(1);
      else if (dly_q != '0)              dly_q <= dly_q - RW'(1);
    end
  end

  assign drive_o  = fall_i;
  assign sample_o = shift_i ? smp_q : rise_i;

  // R10: a delayed capture finishes before the next rising edge arrives
  a_r10_no_overlap: assert property (@(posedge clk) disable iff (rst)
    (dly_q != '0) |-> !rise_i);
  a_r10_one_wide: assert property (@(posedge clk) disable iff (rst)
    smp_q |=> !smp_q);

endmodule

// File: rtl/sfc_clk_cs_timing.sv
module sfc_clk_cs_timing
  import sfc_timing_pkg::*;
#(
  parameter int PRESC_W  = 8,
  parameter int CSHT_W   = 3,
  parameter int CS_COUNT = 2
) (
  input  logic                                    clk,
  input  logic                                    rst,
  input  logic                                    cfg_wr_i,
  input  logic [PRESC_W-1:0]                      cfg_presc_i,
  input  logic [CSHT_W-1:0]                       cfg_csht_i,
  input  logic                                    cfg_idle_high_i,
  input  logic [((CS_COUNT > 1) ? $clog2(CS_COUNT) : 1)-1:0] cfg_sel_i,
  input  logic                                    cfg_sshift_i,
  input  logic                                    xfer_start_i,
  input  logic                                    xfer_stop_i,
  output logic                                    sclk_o,
  output logic [CS_COUNT-1:0]                     cs_n_o,
  output logic                                    drive_stb_o,
  output logic                                    sample_stb_o,
  output logic                                    busy_o
);

  localparam int SEL_W = (CS_COUNT > 1) ? $clog2(CS_COUNT) : 1;
  localparam int RW    = PRESC_W + 1;

  logic [PRESC_W-1:0] presc_q;
  logic [CSHT_W-1:0]  csht_q;
  logic               idle_high_q, sshift_q, busy;
  logic [SEL_W-1:0]   sel_q;
  logic [RW-1:0]      ratio, half;
  logic               rise, fall, period_last;
  xfer_state_e        state;

  sfc_cfg_regs #(
    .PRESC_W(PRESC_W), .CSHT_W(CSHT_W), .SEL_W(SEL_W)
  ) u_cfg (
    .clk(clk), .rst(rst), .wr_i(cfg_wr_i), .busy_i(busy), .start_i(xfer_start_i),
    .presc_i(cfg_presc_i), .csht_i(cfg_csht_i), .idle_high_i(cfg_idle_high_i),
    .sel_i(cfg_sel_i), .sshift_i(cfg_sshift_i),
    .presc_o(presc_q), .csht_o(csht_q), .idle_high_o(idle_high_q),
    .sel_o(sel_q), .sshift_o(sshift_q)
  );

  sfc_sclk_gen #(.PRESC_W(PRESC_W)) u_sclk (
    .clk(clk), .rst(rst), .run_i(state == XS_ACTIVE), .presc_i(presc_q),
    .idle_high_i(idle_high_q), .sclk_o(sclk_o), .rise_o(rise), .fall_o(fall),
    .period_last_o(period_last), .ratio_o(ratio), .half_o(half)
  );

  sfc_xfer_fsm #(
    .CSHT_W(CSHT_W), .RW(RW), .CS_COUNT(CS_COUNT), .SEL_W(SEL_W)
  ) u_fsm (
    .clk(clk), .rst(rst), .start_i(xfer_start_i), .stop_i(xfer_stop_i),
    .period_last_i(period_last), .csht_i(csht_q), .ratio_i(ratio), .sel_i(sel_q),
    .state_o(state), .cs_n_o(cs_n_o), .busy_o(busy)
  );

  sfc_sample_align #(.RW(RW)) u_align (
    .clk(clk), .rst(rst), .rise_i(rise), .fall_i(fall), .half_i(half),
    .shift_i(sshift_q), .drive_o(drive_stb_o), .sample_o(sample_stb_o)
  );

  assign busy_o = busy;

endmodule

// File: tb/sim_sfc_clk_cs_timing.sv
module sim_sfc_clk_cs_timing;

  localparam int CLK_PERIOD = 10;
  localparam int K_CSF = 0, K_CSR = 1, K_SCR = 2, K_SCF = 3, K_DRV = 4, K_SMP = 5, K_BSY = 6;

  logic       clk = 1'b0, rst = 1'b1;
  logic       cfg_wr = 1'b0, cfg_idle = 1'b0, cfg_sel = 1'b0, cfg_shift = 1'b0;
  logic [7:0] cfg_presc = '0;
  logic [2:0] cfg_csht = '0;
  logic       start = 1'b0, stop = 1'b0;
  logic       sclk_o, drive_stb_o, sample_stb_o, busy_o;
  logic [1:0] cs_n_o;

  sfc_clk_cs_timing u0 (
    .clk(clk), .rst(rst), .cfg_wr_i(cfg_wr), .cfg_presc_i(cfg_presc),
    .cfg_csht_i(cfg_csht), .cfg_idle_high_i(cfg_idle), .cfg_sel_i(cfg_sel),
    .cfg_sshift_i(cfg_shift), .xfer_start_i(start), .xfer_stop_i(stop),
    .sclk_o(sclk_o), .cs_n_o(cs_n_o), .drive_stb_o(drive_stb_o),
    .sample_stb_o(sample_stb_o), .busy_o(busy_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct { int kind; int line; int cyc; string req; } ev_t;
  ev_t q[$];

  int cyc = 0, checks = 0, errors = 0;
  int m_presc = 0, m_csht = 0, m_idle = 0, m_sel = 0, m_shift = 0;
  logic mon_en = 1'b0;
  logic [1:0] prev_cs = 2'b11;
  logic prev_sclk = 1'b0, prev_busy = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic push(int kind, int line, int at, string req);
    ev_t e;
    e.kind = kind; e.line = line; e.cyc = at; e.req = req;
    q.push_back(e);
  endtask

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_ev(int kind, int line);
    ev_t e;
    if (q.size() == 0) begin
      checks++; errors++;
      $display("FAIL R6 unexpected event kind %0d line %0d at cycle %0d: actual event expected none",
               kind, line, cyc);
      return;
    end
    e = q.pop_front();
    checks++;
    if (e.kind != kind || e.line != line || e.cyc != cyc) begin
      errors++;
      $display("FAIL %s event: actual kind %0d line %0d cycle %0d expected kind %0d line %0d cycle %0d",
               e.req, kind, line, cyc, e.kind, e.line, e.cyc);
    end
  endtask

  // monitor: scoreboard side, fixed in-cycle event order
  always @(negedge clk) begin
    if (mon_en) begin
      for (int i = 0; i < 2; i++) if (prev_cs[i] && !cs_n_o[i]) check_ev(K_CSF, i);
      for (int i = 0; i < 2; i++) if (!prev_cs[i] && cs_n_o[i]) check_ev(K_CSR, i);
      if (!prev_sclk && sclk_o) check_ev(K_SCR, 0);
      if (prev_sclk && !sclk_o) check_ev(K_SCF, 0);
      if (drive_stb_o) check_ev(K_DRV, 0);
      if (sample_stb_o) check_ev(K_SMP, 0);
      if (prev_busy && !busy_o) check_ev(K_BSY, 0);
    end
    prev_cs = cs_n_o; prev_sclk = sclk_o; prev_busy = busy_o;
  end

  // R11: configuration write while idle; R4 rest level follows two cycles later
  task automatic set_cfg(int presc, int csht, int idle, int sel, int shift);
    while (busy_o) @(negedge clk);
    cfg_wr = 1'b1; cfg_presc = 8'(presc); cfg_csht = 3'(csht);
    cfg_idle = idle[0]; cfg_sel = sel[0]; cfg_shift = shift[0];
    if (idle != m_idle) push(idle ? K_SCR : K_SCF, 0, cyc + 2, "R4");
    m_presc = presc; m_csht = csht; m_idle = idle; m_sel = sel; m_shift = shift;
    @(negedge clk);
    cfg_wr = 1'b0;
    @(negedge clk);
    check(sclk_o == m_idle[0], "R4", "rest level after write", sclk_o, m_idle);
  endtask

  // driver: pushes the expected events of one transfer, then drives it
  task automatic xfer(int periods, bit poke);
    int s, d, h, l, a, g, t1, t2;
    string er;
    while (busy_o) @(negedge clk);
    s = cyc + 1;
    d = (m_presc == 0) ? 2 : m_presc + 1;
    h = d / 2; l = d - h;
    a = m_idle ? h : l;
    g = (m_csht + 1) * d;
    er = (m_presc == 0) ? "R3" : "R2";
    push(K_CSF, m_sel, s, "R5");
    for (int k = 0; k < periods; k++) begin
      t1 = s + k * d + a;
      t2 = s + (k + 1) * d;
      if (m_idle == 0) begin
        push(K_SCR, 0, t1, er);
        if (!m_shift) push(K_SMP, 0, t1, "R9");
      end else begin
        push(K_SCF, 0, t1, er);
        push(K_DRV, 0, t1, "R9");
        if (m_shift && k > 0) push(K_SMP, 0, t1, "R10");
      end
      if (k == periods - 1) push(K_CSR, m_sel, t2, "R7");
      if (m_idle == 0) begin
        push(K_SCF, 0, t2, er);
        push(K_DRV, 0, t2, "R9");
        if (m_shift) push(K_SMP, 0, t2, "R10");
      end else begin
        push(K_SCR, 0, t2, er);
        if (!m_shift) push(K_SMP, 0, t2, "R9");
      end
    end
    if (m_idle != 0 && m_shift) push(K_SMP, 0, s + periods * d + h, "R10");
    push(K_BSY, 0, s + periods * d + g, "R8");

    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat ((periods - 1) * d) @(negedge clk);
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    if (poke) begin
      // R6/R11: inside the gap, a start and an inverted config must be dropped
      repeat (d) @(negedge clk);
      start = 1'b1; cfg_wr = 1'b1;
      cfg_presc = 8'(m_presc) ^ 8'h0F; cfg_csht = 3'(m_csht) ^ 3'h5;
      cfg_idle = ~m_idle[0]; cfg_sel = ~m_sel[0]; cfg_shift = ~m_shift[0];
      @(negedge clk);
      start = 1'b0; cfg_wr = 1'b0;
      @(negedge clk);
      check(cs_n_o == 2'b11, "R6", "start during gap ignored, cs_n", int'(cs_n_o), 3);
    end
    while (busy_o) @(negedge clk);
    check(cs_n_o == 2'b11, "R7", "cs_n after transfer", int'(cs_n_o), 3);
    check(sclk_o == m_idle[0], "R4", "sclk at rest after transfer", sclk_o, m_idle);
    if (poke) begin
      @(negedge clk);
      check(sclk_o == m_idle[0], "R11", "rest level kept after ignored write", sclk_o, m_idle);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R6 watchdog: actual still running expected finished");
    summary();
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check(cs_n_o == 2'b11, "R1", "cs_n after reset", int'(cs_n_o), 3);
    check(sclk_o == 1'b0, "R1", "sclk after reset", sclk_o, 0);
    check(busy_o == 1'b0, "R1", "busy after reset", busy_o, 0);
    check(!drive_stb_o && !sample_stb_o, "R1", "strobes after reset",
          int'({drive_stb_o, sample_stb_o}), 0);
    prev_cs = cs_n_o; prev_sclk = sclk_o; prev_busy = busy_o;
    mon_en = 1'b1;

    set_cfg(3, 1, 0, 0, 0);   xfer(3, 1'b0);  // even ratio, mode 0
    set_cfg(4, 2, 1, 1, 0);   xfer(2, 1'b0);  // odd ratio, mode 3, line 1
    set_cfg(0, 0, 0, 0, 0);   xfer(4, 1'b0);  // fastest clock
    set_cfg(5, 1, 0, 1, 1);   xfer(2, 1'b0);  // shifted capture, mode 0
    set_cfg(2, 0, 1, 0, 1);   xfer(3, 1'b0);  // shifted capture, mode 3, odd
    set_cfg(0, 0, 1, 1, 1);   xfer(2, 1'b0);  // fastest, mode 3, shifted
    set_cfg(6, 3, 0, 0, 0);   xfer(2, 1'b1);  // writes and start inside gap
    xfer(1, 1'b0);                            // old settings still in force
    set_cfg(255, 7, 1, 1, 0); xfer(1, 1'b0);  // slowest clock, longest gap

    repeat (4) @(negedge clk);
    check(q.size() == 0, "R9", "expected events left over", q.size(), 0);
    summary();
    $finish;
  end

endmodule